// File: doc/BRIEF.md
# Replay-Capable Acquisition FIFO with Level Request

This block is a synchronous first-in first-out buffer for a data acquisition card. It holds 4096 words of 16 bits. Three sources can load it: the host, an external general-purpose input strobe, and a fast-recorder snoop. The snoop copies the dataway read lines into the buffer once per dataway read cycle, at the start of its S1 phase, whatever module the cycle addresses. This lets the card log every read word without host involvement. The host drains the buffer later, in idle time.

The buffer reports empty, half-full and full flags. It raises a level request toward the interrupt logic while it is at least half full. Two commands manage it. A replay command rewinds the read side to address zero so the stored words can be read again, which is useful for checking the dataway against preset patterns. An initialise command clears both pointers. A sticky error bit records any refused access.

Top module: `replay_fifo`

## Requirements
- R1: After reset, `empty`=1, `half_full`=0, `full`=0, `lam_req`=0, `err_flag`=0 and `rd_data`=0.
- R2: An accepted write stores one word. Accepted reads return the words in write order. `rd_data` takes the word at the clock edge that accepts the read, so it is visible one cycle after `rd_en` is driven, and it holds its value when no read is accepted.
- R3: The word count runs from 0 to 4096. `empty` is 1 exactly when the count is 0, `full` is 1 exactly when it is 4096, and `half_full` is 1 exactly when it is 2048 or more.
- R4: `lam_req` is 1 whenever `half_full` or `full` is 1, and 0 otherwise.
- R5: A write attempted while `full` is refused: the count and the contents are unchanged. A read attempted while `empty` is refused and `rd_data` holds. Either refusal sets `err_flag`, which stays 1 until an initialise command.
- R6: With `rec_mode` = 1 and `dw_read` = 1, a snoop write of `dw_rdata` happens in the cycle where `dw_s1` is sampled 1 after being sampled 0. While `dw_s1` stays high, no further word is written. With either `rec_mode` or `dw_read` at 0, the S1 line writes nothing.
- R7: At most one word is written per cycle, chosen by priority: snoop first, then `gpin_stb`, then `host_wr`. Words from the losing sources are dropped and do not set `err_flag`.
- R8: `retransmit` sets the read address to zero and leaves the write address and the stored words unchanged. The count is then set to the write address, or to 4096 if the write address has wrapped past 4095 since the last initialise.
- R9: `init_ptr` clears both addresses, the count, the wrap record and `err_flag`. It wins over `retransmit` in the same cycle.
- R10: In any cycle with `init_ptr` or `retransmit` high, read and write requests are ignored without error. Otherwise a read and a write in the same cycle are judged against the flags from before that cycle. When the buffer is neither empty nor full, both are accepted and the count is unchanged. When it is empty, only the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write request |
| host_wdata | input | 16 | Host write word |
| gpin_stb | input | 1 | General-purpose input strobe write request |
| gpin_data | input | 16 | General-purpose input word |
| rec_mode | input | 1 | Fast-recorder snoop enable |
| dw_read | input | 1 | A dataway read cycle is in progress |
| dw_s1 | input | 1 | Dataway S1 phase strobe |
| dw_rdata | input | 16 | Dataway read lines |
| rd_en | input | 1 | Host read request |
| retransmit | input | 1 | Rewind read side to address zero |
| init_ptr | input | 1 | Clear pointers, count and error |
| rd_data | output | 16 | Last word read |
| empty | output | 1 | No word available |
| half_full | output | 1 | At least 2048 words held |
| full | output | 1 | 4096 words held |
| lam_req | output | 1 | Level request toward interrupt logic |
| err_flag | output | 1 | Sticky refused-access indicator |

## Verification
A wrong count shows in the flags. It appears at the next crossing of 0, 2048 or 4096 words, which can come thousands of cycles after the slip itself. The bench therefore compares the flags against its own model on every clock and drives fills across each threshold. A wrong read or write address shows only in `rd_data`, one cycle after a read, so every drained word is compared. Replay and wrap cases are included because a bad rewind count would stay hidden until the replayed data ran out.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;

    localparam int FIFO_DW = 16;
    localparam int FIFO_AW = 12;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_HOST  = 2'd1,
        SRC_GPIN  = 2'd2,
        SRC_SNOOP = 2'd3
    } wsrc_e;

    typedef struct packed {
        logic               valid;
        wsrc_e              src;
        logic [FIFO_DW-1:0] data;
    } wreq_t;

    function automatic int half_mark(input int aw);
        return (1 << aw) / 2;
    endfunction

endpackage

// File: rtl/replay_fifo_wsel.sv
module replay_fifo_wsel
    import replay_fifo_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [FIFO_DW-1:0] host_wdata,
    input  logic               gpin_stb,
    input  logic [FIFO_DW-1:0] gpin_data,
    input  logic               rec_mode,
    input  logic               dw_read,
    input  logic               dw_s1,
    input  logic [FIFO_DW-1:0] dw_rdata,
    output wreq_t              wreq
);

    logic s1_q;
    logic snoop_hit;

    always_ff @(posedge clk) begin
        if (rst) s1_q <= 1'b0;
        else     s1_q <= dw_s1;
    end

    assign snoop_hit = rec_mode && dw_read && dw_s1 && !s1_q;

    always_comb begin
        wreq = '{valid: 1'b0, src: SRC_NONE, data: '0};
        if (snoop_hit) begin
            wreq = '{valid: 1'b1, src: SRC_SNOOP, data: dw_rdata};
        end else if (gpin_stb) begin
            wreq = '{valid: 1'b1, src: SRC_GPIN, data: gpin_data};
        end else if (host_wr) begin
            wreq = '{valid: 1'b1, src: SRC_HOST, data: host_wdata};
        end
    end

    // R6
    snoop_once_chk: assert property (@(posedge clk) disable iff (rst)
        (wreq.src == SRC_SNOOP) |=> (wreq.src != SRC_SNOOP));

    // R7
    snoop_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (wreq.src == SRC_SNOOP) |-> (wreq.data == dw_rdata));

endmodule

// File: rtl/replay_fifo_ctrl.sv
module replay_fifo_ctrl
    import replay_fifo_pkg::*;
#(
    parameter int AW = FIFO_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init_ptr,
    input  logic          retransmit,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          empty,
    output logic          half_full,
    output logic          full,
    output logic          err_flag
);

    localparam int DEPTH = 1 << AW;
    localparam int CW    = AW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C  = CW'(half_mark(AW));
    localparam logic [AW-1:0] LAST_A  = AW'(DEPTH - 1);

    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          wrapped;
    logic          err_q;
    logic          cmd_idle;

    assign cmd_idle  = !init_ptr && !retransmit;
    assign empty     = (count == '0);
    assign full      = (count == DEPTH_C);
    assign half_full = (count >= HALF_C);
    assign wr_go     = cmd_idle && wr_req && !full;
    assign rd_go     = cmd_idle && rd_req && !empty;
    assign waddr     = wptr;
    assign raddr     = rptr;
    assign err_flag  = err_q;

    always_ff @(posedge clk) begin
        if (rst || init_ptr) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            wrapped <= 1'b0;
            err_q   <= 1'b0;
        end else if (retransmit) begin
            rptr  <= '0;
            count <= wrapped ? DEPTH_C : {1'b0, wptr};
        end else begin
            if ((wr_req && full) || (rd_req && empty)) err_q <= 1'b1;
            if (wr_go) begin
                wptr <= wptr + 1'b1;
                if (wptr == LAST_A) wrapped <= 1'b1;
            end
            if (rd_go) rptr <= rptr + 1'b1;
            case ({wr_go, rd_go})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= DEPTH_C);

    // R3
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !init_ptr) |=> err_q);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (full && cmd_idle && !rd_req) |=> full && $stable(wptr));

    // R8
    rewind_chk: assert property (@(posedge clk) disable iff (rst)
        (retransmit && !init_ptr) |=> (rptr == '0) && $stable(wptr));

    // R9
    init_clear_chk: assert property (@(posedge clk) disable iff (rst)
        init_ptr |=> empty && !err_q && (wptr == '0));

endmodule

// File: rtl/replay_fifo_mem.sv
module replay_fifo_mem
    import replay_fifo_pkg::*;
#(
    parameter int AW = FIFO_AW,
    parameter int DW = FIFO_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= store[raddr];
    end

endmodule

// File: rtl/replay_fifo.sv
module replay_fifo
    import replay_fifo_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [FIFO_DW-1:0] host_wdata,
    input  logic               gpin_stb,
    input  logic [FIFO_DW-1:0] gpin_data,
    input  logic               rec_mode,
    input  logic               dw_read,
    input  logic               dw_s1,
    input  logic [FIFO_DW-1:0] dw_rdata,
    input  logic               rd_en,
    input  logic               retransmit,
    input  logic               init_ptr,
    output logic [FIFO_DW-1:0] rd_data,
    output logic               empty,
    output logic               half_full,
    output logic               full,
    output logic               lam_req,
    output logic               err_flag
);

    wreq_t              wreq;
    logic               wr_go, rd_go;
    logic [FIFO_AW-1:0] waddr, raddr;

    replay_fifo_wsel u_wsel (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .gpin_stb   (gpin_stb),
        .gpin_data  (gpin_data),
        .rec_mode   (rec_mode),
        .dw_read    (dw_read),
        .dw_s1      (dw_s1),
        .dw_rdata   (dw_rdata),
        .wreq       (wreq)
    );

    replay_fifo_ctrl #(.AW(FIFO_AW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .init_ptr   (init_ptr),
        .retransmit (retransmit),
        .wr_req     (wreq.valid),
        .rd_req     (rd_en),
        .wr_go      (wr_go),
        .rd_go      (rd_go),
        .waddr      (waddr),
        .raddr      (raddr),
        .empty      (empty),
        .half_full  (half_full),
        .full       (full),
        .err_flag   (err_flag)
    );

    replay_fifo_mem #(.AW(FIFO_AW), .DW(FIFO_DW)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_go),
        .waddr (waddr),
        .wdata (wreq.data),
        .re    (rd_go),
        .raddr (raddr),
        .rdata (rd_data)
    );

    assign lam_req = half_full || full;

    // R4
    lam_full_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> lam_req);

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> $stable(rd_data));

endmodule

// File: tb/replay_fifo_tb.sv
module replay_fifo_tb;

    localparam int DEPTH = 4096;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr, gpin_stb, rec_mode, dw_read, dw_s1;
    logic [15:0] host_wdata, gpin_data, dw_rdata;
    logic        rd_en, retransmit, init_ptr;
    logic [15:0] rd_data;
    logic        empty, half_full, full, lam_req, err_flag;

    always #4 clk = ~clk;

    replay_fifo u_dut (.*);

    // behavioural reference model
    int          m_mem [DEPTH];
    int          m_w, m_r, m_cnt;
    bit          m_wrap, m_err, m_s1p;
    logic [15:0] m_rd;

    always @(posedge clk) begin
        bit          wv, do_w, do_r;
        logic [15:0] wd;
        if (rst) begin
            m_w = 0; m_r = 0; m_cnt = 0; m_wrap = 0; m_err = 0; m_rd = '0;
        end else if (init_ptr) begin
            m_w = 0; m_r = 0; m_cnt = 0; m_wrap = 0; m_err = 0;
        end else if (retransmit) begin
            m_r = 0;
            m_cnt = m_wrap ? DEPTH : m_w;
        end else begin
            wv = 1'b1;
            if (rec_mode && dw_read && dw_s1 && !m_s1p) wd = dw_rdata;
            else if (gpin_stb) wd = gpin_data;
            else if (host_wr)  wd = host_wdata;
            else begin wv = 1'b0; wd = '0; end
            do_w = wv && (m_cnt < DEPTH);
            do_r = rd_en && (m_cnt > 0);
            if (wv && m_cnt == DEPTH) m_err = 1;
            if (rd_en && m_cnt == 0)  m_err = 1;
            if (do_r) begin
                m_rd = m_mem[m_r][15:0];
                m_r = (m_r + 1) % DEPTH;
            end
            if (do_w) begin
                m_mem[m_w] = int'(wd);
                if (m_w == DEPTH - 1) m_wrap = 1;
                m_w = (m_w + 1) % DEPTH;
            end
            m_cnt = m_cnt + int'(do_w) - int'(do_r);
        end
        m_s1p = rst ? 1'b0 : dw_s1;
    end

    int    checks = 0;
    int    errors = 0;
    string phase = "R1";

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) actual=%0h expected=%0h at %0t", tag, phase, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3 empty", int'(empty), int'(m_cnt == 0));
        chk("R3 full", int'(full), int'(m_cnt == DEPTH));
        chk("R3 half_full", int'(half_full), int'(m_cnt >= DEPTH / 2));
        chk("R4 lam_req", int'(lam_req), int'(m_cnt >= DEPTH / 2));
        chk("R5 err_flag", int'(err_flag), int'(m_err));
        chk("R2 rd_data", int'(rd_data), int'(m_rd));
    endtask

    task automatic idle_inputs();
        host_wr = 0; gpin_stb = 0; rec_mode = 0; dw_read = 0; dw_s1 = 0;
        rd_en = 0; retransmit = 0; init_ptr = 0;
        host_wdata = '0; gpin_data = '0; dw_rdata = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (!rst) compare_all();
        idle_inputs();
    endtask

    task automatic hwrite(input logic [15:0] d);
        host_wr = 1; host_wdata = d; tick();
    endtask

    task automatic hread();
        rd_en = 1; tick();
    endtask

    int wd_cnt = 0;
    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        tick(); tick();
        rst = 0;
        tick();
        // R1 reset state
        phase = "R1";
        chk("R1 empty", int'(empty), 1);
        chk("R1 lam_req", int'(lam_req), 0);
        chk("R1 err_flag", int'(err_flag), 0);
        chk("R1 rd_data", int'(rd_data), 0);

        // R2 ordering
        phase = "R2";
        for (int i = 0; i < 5; i++) hwrite(16'h1000 + 16'(i));
        for (int i = 0; i < 5; i++) begin
            hread();
            chk("R2 order", int'(rd_data), 16'h1000 + i);
        end
        chk("R2 drained", int'(empty), 1);

        // R6 snoop capture on S1 rise only
        phase = "R6";
        rec_mode = 1; dw_read = 1; dw_s1 = 0; dw_rdata = 16'hBEEF; tick();
        for (int i = 0; i < 3; i++) begin
            rec_mode = 1; dw_read = 1; dw_s1 = 1; dw_rdata = 16'hBEE0 + 16'(i);
            tick();
        end
        rec_mode = 0; dw_read = 1; tick();
        dw_read = 1; dw_s1 = 1; dw_rdata = 16'h7777; tick();
        rec_mode = 1; dw_read = 0; tick();
        rec_mode = 1; dw_read = 0; dw_s1 = 1; dw_rdata = 16'h6666; tick();
        hread();
        chk("R6 captured word", int'(rd_data), 16'hBEE0);
        chk("R6 single capture", int'(empty), 1);

        // R7 priority
        phase = "R7";
        rec_mode = 1; dw_read = 1; dw_s1 = 1; dw_rdata = 16'hA001;
        gpin_stb = 1; gpin_data = 16'hA002; host_wr = 1; host_wdata = 16'hA003; tick();
        gpin_stb = 1; gpin_data = 16'hB002; host_wr = 1; host_wdata = 16'hB003; tick();
        hread();
        chk("R7 snoop wins", int'(rd_data), 16'hA001);
        hread();
        chk("R7 strobe beats host", int'(rd_data), 16'hB002);
        chk("R7 one word per cycle", int'(empty), 1);
        chk("R7 no error", int'(err_flag), 0);

        // R3/R4 thresholds
        phase = "R3";
        init_ptr = 1; tick();
        for (int i = 0; i < DEPTH / 2 - 1; i++) hwrite(16'(i * 3));
        chk("R3 below half", int'(half_full), 0);
        hwrite(16'hC0DE);
        chk("R3 at half", int'(half_full), 1);
        chk("R4 lam at half", int'(lam_req), 1);
        for (int i = DEPTH / 2; i < DEPTH; i++) hwrite(16'(i * 3));
        chk("R3 full", int'(full), 1);

        // R5 overflow refused
        phase = "R5";
        hwrite(16'hDEAD);
        chk("R5 overflow err", int'(err_flag), 1);
        chk("R5 still full", int'(full), 1);
        hread();
        chk("R5 contents kept", int'(rd_data), 0);

        // R10 simultaneous read and write mid-level
        phase = "R10";
        host_wr = 1; host_wdata = 16'h5A5A; rd_en = 1; tick();
        chk("R10 rd in same cycle", int'(rd_data), 3);
        chk("R10 count kept", int'(full), 0);

        // R8 replay after a wrap
        phase = "R8";
        for (int i = 0; i < DEPTH - 2; i++) hread();
        hwrite(16'h0E01); hwrite(16'h0E02);
        retransmit = 1; tick();
        chk("R8 wrapped rewind count", int'(full), 1);
        hread();
        chk("R8 replay word0", int'(rd_data), 16'h5A5A);
        hread();
        chk("R8 replay word1", int'(rd_data), 16'h0E01);

        // R9 init over retransmit, requests ignored
        phase = "R9";
        init_ptr = 1; retransmit = 1; host_wr = 1; host_wdata = 16'h1111; tick();
        chk("R9 cleared empty", int'(empty), 1);
        chk("R9 cleared err", int'(err_flag), 0);
        hwrite(16'h2222); hwrite(16'h3333); hread();
        retransmit = 1; rd_en = 1; host_wr = 1; host_wdata = 16'h4444; tick();
        hread();
        chk("R8 replay from zero", int'(rd_data), 16'h2222);
        hread();
        chk("R8 second replay word", int'(rd_data), 16'h3333);
        chk("R10 write ignored in rewind", int'(empty), 1);

        // R10 empty with read and write together; R5 underflow
        phase = "R10";
        rd_en = 1; host_wr = 1; host_wdata = 16'h9999; tick();
        chk("R10 write accepted when empty", int'(empty), 0);
        chk("R5 underflow err", int'(err_flag), 1);
        hread();
        chk("R10 stored word", int'(rd_data), 16'h9999);
        hread();
        chk("R5 rd holds on underflow", int'(rd_data), 16'h9999);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule